// File: doc/BRIEF.md
# Octal RAM Mode-Register Bring-Up Controller

This block brings an octal-interface pseudo-static RAM from power-up to a known configuration. On a start pulse it switches the memory clock request to a slow divider and drives a sequence of six register accesses through an external transaction engine. Each access is issued with a one-cycle `txn_start` pulse. The descriptor stays stable until the engine returns `txn_done`. The first access reads the low mode-register pair. The second writes that pair back with only the latency-type, read-latency and drive-strength fields replaced. The last four read back the registers that identify and describe the device.

After the last read, the controller checks the vendor code and turns the sparse density code into a byte count. It also decodes the device generation, the good-die flag, the read latency in cycles, the write-latency code and the burst settings. It then leaves slow mode. Only when the device is identified does it pulse a request to return the memory clock to full speed. A lost `txn_done` is caught by a per-access timeout, which ends the sequence with an error.

Top module: `oram_bringup`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `err_timeout`, `fast_req` and `txn_start` are 0, `size_bytes` is 0 and `mem_clk_div` equals FAST_DIV.
- R2: One start produces exactly six accesses, in this order: read address 0, write address 0, read address 0, read address 2, read address 4 and read address 8. Reads use command 0x4040 and RD_DUMMY (18) dummy bits. The write uses command 0xC0C0 with 0 dummy bits. The lengths are 16, 16, 16, 16, 8 and 8 bits. `txn_write` is 1 only for the second access. The 8-bit reads take `txn_rdata[7:0]`.
- R3: `txn_start` is a one-cycle pulse. The next access is issued in the cycle after `txn_done` is sampled. The descriptor outputs are stable while an access waits.
- R4: The written word keeps the high byte exactly as read by the first access. Its low byte keeps bits [7:6] as read and sets bit 5 = 1 (fixed latency), bits [4:2] = 2 (latency code) and bits [1:0] = 0 (drive strength).
- R5: `mem_clk_div` equals SLOW_DIV (4) from the cycle after start until the cycle in which `done` rises. It then returns to FAST_DIV.
- R6: The vendor code is bits [4:0] of the high byte of the third access. If it equals 0x0D, `done` rises with `error` = 0 and `fast_req` pulses for exactly one cycle. Otherwise `done` and `error` rise, `size_bytes` is 0 and `fast_req` stays 0.
- R7: The density code is bits [2:0] of the low byte of the read at address 2. Codes 0, 1, 3, 5 and 7 give 2, 4, 8, 16 and 32 MiB. Codes 2, 4 and 6 give 0.
- R8: On success the outputs are as follows. `dev_gen` = address-2 low byte bits [4:3] + 1. `good_die` = that byte's bit 7. `fixed_lat` = re-read MR0 bit 5. `rd_lat_cycles` = re-read MR0 bits [4:2] × 2 + 6. `wr_lat_code` = address-4 byte bits [7:5]. `burst_len_code` = address-8 byte bits [1:0]. `burst_hybrid` = address-8 byte bit 2.
- R9: If `txn_done` has not arrived by the TIMEOUT_CYCLES-th cycle after `txn_start`, the next cycle shows `done`, `error` and `err_timeout` at 1 and `fast_req` at 0. A `txn_done` in that last cycle is still accepted. No further access is issued.
- R10: A start pulse while `busy` is ignored, including one that coincides with `txn_done`.
- R11: Results hold unchanged while idle. A new start clears `done`, `error` and `err_timeout` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the bring-up sequence |
| busy | output | 1 | Sequence in progress |
| txn_start | output | 1 | One-cycle pulse that issues an access |
| txn_write | output | 1 | Access is a register write |
| txn_cmd | output | 16 | Command word |
| txn_addr | output | ADDR_W | Register address |
| txn_bits | output | LEN_W | Data length in bits |
| txn_dummy | output | LEN_W | Dummy bits before data |
| txn_wdata | output | 16 | Write data |
| txn_done | input | 1 | Access finished |
| txn_rdata | input | 16 | Read data, valid with txn_done |
| mem_clk_div | output | DIV_W | Requested memory clock divider |
| fast_req | output | 1 | One-cycle request to return to full speed |
| done | output | 1 | Sequence ended |
| error | output | 1 | Sequence ended in failure |
| err_timeout | output | 1 | Failure was a lost access |
| vendor_id | output | 5 | Vendor code read |
| size_bytes | output | 32 | Detected capacity in bytes |
| dev_gen | output | 3 | Device generation |
| good_die | output | 1 | Good-die flag |
| fixed_lat | output | 1 | Latency type is fixed |
| rd_lat_cycles | output | 5 | Read latency in clock cycles |
| wr_lat_code | output | 3 | Write-latency code |
| burst_len_code | output | 2 | Burst-length code |
| burst_hybrid | output | 1 | Burst-type bit |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the timeout expiry and the completion of an access. The bench returns `txn_done` in exactly the last allowed wait cycle and expects the access to be accepted with no error. In another run it withholds `txn_done` and expects the timeout in the very next cycle. The second pair is a new start and a completing access. The bench raises `start` in the same cycle as `txn_done` and expects the sequence to continue unchanged, with no restart and no extra access.

// File: rtl/oram_pkg.sv
package oram_pkg;

    localparam logic [15:0] CMD_REG_RD = 16'h4040;
    localparam logic [15:0] CMD_REG_WR = 16'hC0C0;
    localparam int SIZE_W   = 32;
    localparam int VEND_W   = 5;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_INIT,
        ST_WR_MR0,
        ST_RD_01,
        ST_RD_23,
        ST_RD_4,
        ST_RD_8,
        ST_CHECK
    } step_e;

    typedef struct packed {
        logic [SIZE_W-1:0] size_bytes;
        logic [2:0]        gen;
        logic              good_die;
        logic              fixed_lat;
        logic [4:0]        rd_lat;
        logic [2:0]        wl_code;
        logic [1:0]        bl_code;
        logic              bt;
        logic [VEND_W-1:0] vendor;
    } id_info_t;

    function automatic logic is_access(step_e s);
        return (s != ST_IDLE) && (s != ST_CHECK);
    endfunction

    function automatic logic [SIZE_W-1:0] density_bytes(logic [2:0] code);
        logic [SIZE_W-1:0] r;
        case (code)
            3'd0:    r = SIZE_W'(32'h0020_0000);
            3'd1:    r = SIZE_W'(32'h0040_0000);
            3'd3:    r = SIZE_W'(32'h0080_0000);
            3'd5:    r = SIZE_W'(32'h0100_0000);
            3'd7:    r = SIZE_W'(32'h0200_0000);
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/oram_wait_timer.sv
module oram_wait_timer #(
    parameter int TIMEOUT_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic waiting,
    input  logic done_in,
    output logic expired
);
    localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (arm) begin
            cnt_d = '0;
        end else if (waiting && (cnt_q != LAST)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = waiting && !done_in && (cnt_q == LAST);

endmodule

// File: rtl/oram_mr_merge.sv
module oram_mr_merge #(
    parameter logic       LAT_TYPE  = 1'b1,
    parameter logic [2:0] LAT_CODE  = 3'd2,
    parameter logic [1:0] DRIVE_STR = 2'd0
) (
    input  logic [1:0] keep_hi,
    output logic [7:0] mr_new
);
    always_comb begin
        mr_new = {keep_hi, LAT_TYPE, LAT_CODE, DRIVE_STR};
    end
endmodule

// File: rtl/oram_id_decode.sv
module oram_id_decode
    import oram_pkg::*;
#(
    parameter logic [VEND_W-1:0] VENDOR_CODE = 5'h0D
) (
    input  logic [3:0]        mr0_lat,
    input  logic [VEND_W-1:0] vendor,
    input  logic [5:0]        mr2_fld,
    input  logic [2:0]        wl_code,
    input  logic [2:0]        burst_fld,
    output logic              vendor_ok,
    output id_info_t          info
);
    always_comb begin
        vendor_ok       = (vendor == VENDOR_CODE);
        info.size_bytes = density_bytes(mr2_fld[2:0]);
        info.gen        = 3'(mr2_fld[4:3]) + 3'd1;
        info.good_die   = mr2_fld[5];
        info.fixed_lat  = mr0_lat[3];
        info.rd_lat     = {1'b0, mr0_lat[2:0], 1'b0} + 5'd6;
        info.wl_code    = wl_code;
        info.bl_code    = burst_fld[1:0];
        info.bt         = burst_fld[2];
        info.vendor     = vendor;
    end
endmodule

// File: rtl/oram_bringup.sv
module oram_bringup
    import oram_pkg::*;
#(
    parameter int         ADDR_W         = 32,
    parameter int         LEN_W          = 6,
    parameter int         DIV_W          = 4,
    parameter int         SLOW_DIV       = 4,
    parameter int         FAST_DIV       = 2,
    parameter int         RD_DUMMY       = 18,
    parameter int         TIMEOUT_CYCLES = 4096,
    parameter logic [4:0] VENDOR_CODE    = 5'h0D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              txn_start,
    output logic              txn_write,
    output logic [15:0]       txn_cmd,
    output logic [ADDR_W-1:0] txn_addr,
    output logic [LEN_W-1:0]  txn_bits,
    output logic [LEN_W-1:0]  txn_dummy,
    output logic [15:0]       txn_wdata,
    input  logic              txn_done,
    input  logic [15:0]       txn_rdata,
    output logic [DIV_W-1:0]  mem_clk_div,
    output logic              fast_req,
    output logic              done,
    output logic              error,
    output logic              err_timeout,
    output logic [4:0]        vendor_id,
    output logic [31:0]       size_bytes,
    output logic [2:0]        dev_gen,
    output logic              good_die,
    output logic              fixed_lat,
    output logic [4:0]        rd_lat_cycles,
    output logic [2:0]        wr_lat_code,
    output logic [1:0]        burst_len_code,
    output logic              burst_hybrid
);

    localparam logic [LEN_W-1:0] LEN_WORD = LEN_W'(16);
    localparam logic [LEN_W-1:0] LEN_BYTE = LEN_W'(8);
    localparam logic [LEN_W-1:0] DUMMY_RD = LEN_W'(RD_DUMMY);

    typedef struct packed {
        step_e       step;
        logic        waiting;
        logic        slow;
        logic        done;
        logic        error;
        logic        timeout;
        logic        fast;
        logic [15:0] wdata;
        logic [3:0]  mr0_lat;
        logic [4:0]  vendor;
        logic [5:0]  mr2_fld;
        logic [2:0]  wl;
        logic [2:0]  burst;
        id_info_t    info;
    } state_t;

    state_t   st_d, st_q;
    logic     expired;
    logic     vendor_ok;
    id_info_t dec_info;
    logic [7:0] mr0_merged;

    // Access timeout
    oram_wait_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (txn_start),
        .waiting (st_q.waiting),
        .done_in (txn_done),
        .expired (expired)
    );

    // Read-modify-write of the low mode byte
    oram_mr_merge #(.LAT_TYPE(1'b1), .LAT_CODE(3'd2), .DRIVE_STR(2'd0)) u_merge (
        .keep_hi (txn_rdata[7:6]),
        .mr_new  (mr0_merged)
    );

    // Identification decode
    oram_id_decode #(.VENDOR_CODE(VENDOR_CODE)) u_decode (
        .mr0_lat   (st_q.mr0_lat),
        .vendor    (st_q.vendor),
        .mr2_fld   (st_q.mr2_fld),
        .wl_code   (st_q.wl),
        .burst_fld (st_q.burst),
        .vendor_ok (vendor_ok),
        .info      (dec_info)
    );

    // Access descriptor per step
    always_comb begin
        txn_write = 1'b0;
        txn_addr  = '0;
        txn_bits  = '0;
        txn_dummy = '0;
        txn_cmd   = '0;
        case (st_q.step)
            ST_RD_INIT, ST_RD_01: begin
                txn_bits = LEN_WORD;
            end
            ST_WR_MR0: begin
                txn_write = 1'b1;
                txn_bits  = LEN_WORD;
            end
            ST_RD_23: begin
                txn_addr = ADDR_W'(2);
                txn_bits = LEN_WORD;
            end
            ST_RD_4: begin
                txn_addr = ADDR_W'(4);
                txn_bits = LEN_BYTE;
            end
            ST_RD_8: begin
                txn_addr = ADDR_W'(8);
                txn_bits = LEN_BYTE;
            end
            default: ;
        endcase
        if (is_access(st_q.step)) begin
            txn_cmd   = txn_write ? CMD_REG_WR : CMD_REG_RD;
            txn_dummy = txn_write ? '0 : DUMMY_RD;
        end
    end

    // Next-state logic
    always_comb begin
        st_d      = st_q;
        st_d.fast = 1'b0;
        case (st_q.step)
            ST_IDLE: begin
                if (start) begin
                    st_d.step    = ST_RD_INIT;
                    st_d.waiting = 1'b0;
                    st_d.slow    = 1'b1;
                    st_d.done    = 1'b0;
                    st_d.error   = 1'b0;
                    st_d.timeout = 1'b0;
                    st_d.info    = '0;
                end
            end
            ST_CHECK: begin
                st_d.step = ST_IDLE;
                st_d.slow = 1'b0;
                st_d.done = 1'b1;
                if (vendor_ok) begin
                    st_d.info = dec_info;
                    st_d.fast = 1'b1;
                end else begin
                    st_d.error       = 1'b1;
                    st_d.info        = '0;
                    st_d.info.vendor = dec_info.vendor;
                end
            end
            default: begin
                if (!st_q.waiting) begin
                    st_d.waiting = 1'b1;
                end else if (txn_done) begin
                    st_d.waiting = 1'b0;
                    case (st_q.step)
                        ST_RD_INIT: begin
                            st_d.wdata = {txn_rdata[15:8], mr0_merged};
                            st_d.step  = ST_WR_MR0;
                        end
                        ST_WR_MR0: st_d.step = ST_RD_01;
                        ST_RD_01: begin
                            st_d.mr0_lat = txn_rdata[5:2];
                            st_d.vendor  = txn_rdata[12:8];
                            st_d.step    = ST_RD_23;
                        end
                        ST_RD_23: begin
                            st_d.mr2_fld = {txn_rdata[7], txn_rdata[4:0]};
                            st_d.step    = ST_RD_4;
                        end
                        ST_RD_4: begin
                            st_d.wl   = txn_rdata[7:5];
                            st_d.step = ST_RD_8;
                        end
                        default: begin
                            st_d.burst = txn_rdata[2:0];
                            st_d.step  = ST_CHECK;
                        end
                    endcase
                end else if (expired) begin
                    st_d.waiting = 1'b0;
                    st_d.step    = ST_IDLE;
                    st_d.slow    = 1'b0;
                    st_d.done    = 1'b1;
                    st_d.error   = 1'b1;
                    st_d.timeout = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy           = (st_q.step != ST_IDLE);
    assign txn_start      = is_access(st_q.step) && !st_q.waiting;
    assign txn_wdata      = st_q.wdata;
    assign mem_clk_div    = st_q.slow ? DIV_W'(SLOW_DIV) : DIV_W'(FAST_DIV);
    assign fast_req       = st_q.fast;
    assign done           = st_q.done;
    assign error          = st_q.error;
    assign err_timeout    = st_q.timeout;
    assign vendor_id      = st_q.info.vendor;
    assign size_bytes     = st_q.info.size_bytes;
    assign dev_gen        = st_q.info.gen;
    assign good_die       = st_q.info.good_die;
    assign fixed_lat      = st_q.info.fixed_lat;
    assign rd_lat_cycles  = st_q.info.rd_lat;
    assign wr_lat_code    = st_q.info.wl_code;
    assign burst_len_code = st_q.info.bl_code;
    assign burst_hybrid   = st_q.info.bt;

endmodule

// File: rtl/oram_bringup_sva.sv
module oram_bringup_sva #(
    parameter int DIV_W    = 4,
    parameter int SLOW_DIV = 4,
    parameter int ADDR_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              txn_start,
    input logic              txn_done,
    input logic [ADDR_W-1:0] txn_addr,
    input logic [DIV_W-1:0]  mem_clk_div,
    input logic              fast_req,
    input logic              done,
    input logic              error,
    input logic              err_timeout,
    input logic [31:0]       size_bytes
);
    // R3: issue pulse lasts one cycle
    a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        txn_start |=> !txn_start);

    // R3: address held while an access waits
    a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_start && !txn_done) |=> $stable(txn_addr));

    // R5: slow divider whenever a sequence runs
    a_r5_slow_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (mem_clk_div == DIV_W'(SLOW_DIV)));

    // R6: full-speed request only after clean identification
    a_r6_fast_only_ok: assert property (@(posedge clk) disable iff (!rst_n)
        fast_req |-> (done && !error && !busy));

    // R6: no size reported on failure
    a_r6_no_size_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (size_bytes == 32'd0));

    // R9: timeout is reported as an error
    a_r9_timeout_is_error: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> (error && done));

    // R11: results hold while idle
    a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(done) && $stable(size_bytes) && $stable(error)));
endmodule

bind oram_bringup oram_bringup_sva #(
    .DIV_W    (DIV_W),
    .SLOW_DIV (SLOW_DIV),
    .ADDR_W   (ADDR_W)
) i_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .txn_start   (txn_start),
    .txn_done    (txn_done),
    .txn_addr    (txn_addr),
    .mem_clk_div (mem_clk_div),
    .fast_req    (fast_req),
    .done        (done),
    .error       (error),
    .err_timeout (err_timeout),
    .size_bytes  (size_bytes)
);

// File: tb/test_oram_bringup.sv
`timescale 1ns/1ps
module test_oram_bringup;
    localparam int TO = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        busy, txn_start, txn_write;
    logic [15:0] txn_cmd, txn_wdata;
    logic [31:0] txn_addr;
    logic [5:0]  txn_bits, txn_dummy;
    logic        txn_done = 1'b0;
    logic [15:0] txn_rdata = 16'h0;
    logic [3:0]  mem_clk_div;
    logic        fast_req, done, error, err_timeout;
    logic [4:0]  vendor_id;
    logic [31:0] size_bytes;
    logic [2:0]  dev_gen;
    logic        good_die, fixed_lat;
    logic [4:0]  rd_lat_cycles;
    logic [2:0]  wr_lat_code;
    logic [1:0]  burst_len_code;
    logic        burst_hybrid;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    oram_bringup #(.TIMEOUT_CYCLES(TO)) i_oram_bringup (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
        .txn_start(txn_start), .txn_write(txn_write), .txn_cmd(txn_cmd),
        .txn_addr(txn_addr), .txn_bits(txn_bits), .txn_dummy(txn_dummy),
        .txn_wdata(txn_wdata), .txn_done(txn_done), .txn_rdata(txn_rdata),
        .mem_clk_div(mem_clk_div), .fast_req(fast_req), .done(done),
        .error(error), .err_timeout(err_timeout), .vendor_id(vendor_id),
        .size_bytes(size_bytes), .dev_gen(dev_gen), .good_die(good_die),
        .fixed_lat(fixed_lat), .rd_lat_cycles(rd_lat_cycles),
        .wr_lat_code(wr_lat_code), .burst_len_code(burst_len_code),
        .burst_hybrid(burst_hybrid)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual 0x%0h expected 0x%0h", req, $time, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic longint ref_size(input logic [2:0] c);
        case (c)
            3'd0: return 64'd2 * 1024 * 1024;
            3'd1: return 64'd4 * 1024 * 1024;
            3'd3: return 64'd8 * 1024 * 1024;
            3'd5: return 64'd16 * 1024 * 1024;
            3'd7: return 64'd32 * 1024 * 1024;
            default: return 64'd0;
        endcase
    endfunction

    // Per-cycle comparison of the sequencing outputs
    task automatic cyc(input bit e_start, input bit e_slow, input bit e_busy, input string req);
        check(txn_start == e_start, {req, " txn_start"}, txn_start, e_start);
        check(mem_clk_div == (e_slow ? 4'd4 : 4'd2), "R5 clk_div", mem_clk_div, e_slow ? 4 : 2);
        check(busy == e_busy, {req, " busy"}, busy, e_busy);
    endtask

    task automatic run_seq(input logic [7:0] m0, input logic [7:0] m1, input logic [7:0] m2,
                           input logic [7:0] m3, input logic [7:0] m4, input logic [7:0] m8,
                           input bit ign_wr, input int dly, input int long_step,
                           input int long_dly, input int hang_step, input bit poke);
        logic [7:0]  dev0 = m0;
        logic [15:0] exp_w = {m1, (m0 & 8'hC0) | 8'h28};
        logic [7:0]  rb0;
        bit          ok;
        int          d;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!done && !error && !err_timeout, "R11 clear on start", {done, error}, 0);
        for (int i = 0; i < 6; i++) begin
            logic [31:0] ea;
            logic [5:0]  eb;
            bit          ew;
            logic [15:0] rd;
            ew = (i == 1);
            ea = (i == 3) ? 32'd2 : (i == 4) ? 32'd4 : (i == 5) ? 32'd8 : 32'd0;
            eb = (i >= 4) ? 6'd8 : 6'd16;
            cyc(1'b1, 1'b1, 1'b1, "R2");
            check(txn_write == ew, "R2 write flag", txn_write, ew);
            check(txn_addr == ea, "R2 address", txn_addr, ea);
            check(txn_bits == eb, "R2 length", txn_bits, eb);
            check(txn_dummy == (ew ? 6'd0 : 6'd18), "R2 dummy", txn_dummy, ew ? 0 : 18);
            check(txn_cmd == (ew ? 16'hC0C0 : 16'h4040), "R2 command", txn_cmd, ew ? 16'hC0C0 : 16'h4040);
            if (ew) begin
                check(txn_wdata == exp_w, "R4 write data", txn_wdata, exp_w);
                if (!ign_wr) dev0 = exp_w[7:0];
            end
            if (i == hang_step) begin
                for (int k = 1; k <= TO; k++) begin
                    @(negedge clk);
                    cyc(1'b0, 1'b1, 1'b1, "R9 waiting");
                    check(!error, "R9 early error", error, 0);
                end
                @(negedge clk);
                cyc(1'b0, 1'b0, 1'b0, "R9 expired");
                check(error && err_timeout && done, "R9 timeout flags", {done, error, err_timeout}, 3'b111);
                check(!fast_req, "R9 no fast request", fast_req, 0);
                for (int k = 0; k < 3; k++) begin
                    @(negedge clk);
                    cyc(1'b0, 1'b0, 1'b0, "R9 no more access");
                end
                return;
            end
            d = (i == long_step) ? long_dly : dly;
            for (int k = 1; k < d; k++) begin
                @(negedge clk);
                start = poke && (k == 1);
                cyc(1'b0, 1'b1, 1'b1, "R3 wait");
                check(txn_addr == ea, "R3 descriptor stable", txn_addr, ea);
            end
            @(negedge clk);
            start = poke;
            cyc(1'b0, 1'b1, 1'b1, "R3 wait");
            case (i)
                0, 2:    rd = {m1, dev0};
                3:       rd = {m3, m2};
                4:       rd = {8'hFF, m4};
                5:       rd = {8'hFF, m8};
                default: rd = 16'h0;
            endcase
            txn_done  = 1'b1;
            txn_rdata = rd;
            @(negedge clk);
            txn_done  = 1'b0;
            txn_rdata = 16'h0;
            start     = 1'b0;
        end
        cyc(1'b0, 1'b1, 1'b1, "R10 check step");
        check(!done, "R6 done not early", done, 0);
        @(negedge clk);
        rb0 = ign_wr ? m0 : exp_w[7:0];
        ok  = (m1[4:0] == 5'h0D);
        cyc(1'b0, 1'b0, 1'b0, "R6 end");
        check(done, "R6 done", done, 1);
        check(error == !ok, "R6 error", error, !ok);
        check(fast_req == ok, "R6 fast request", fast_req, ok);
        check(vendor_id == m1[4:0], "R6 vendor", vendor_id, m1[4:0]);
        check(size_bytes == (ok ? ref_size(m2[2:0]) : 0), "R7 size", size_bytes, ok ? ref_size(m2[2:0]) : 0);
        if (ok) begin
            check(dev_gen == m2[4:3] + 1, "R8 generation", dev_gen, m2[4:3] + 1);
            check(good_die == m2[7], "R8 good die", good_die, m2[7]);
            check(fixed_lat == rb0[5], "R8 latency type", fixed_lat, rb0[5]);
            check(rd_lat_cycles == rb0[4:2] * 2 + 6, "R8 read latency", rd_lat_cycles, rb0[4:2] * 2 + 6);
            check(wr_lat_code == m4[7:5], "R8 write latency", wr_lat_code, m4[7:5]);
            check(burst_len_code == m8[1:0], "R8 burst length", burst_len_code, m8[1:0]);
            check(burst_hybrid == m8[2], "R8 burst type", burst_hybrid, m8[2]);
        end
        @(negedge clk);
        check(!fast_req, "R6 fast pulse one cycle", fast_req, 0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            cyc(1'b0, 1'b0, 1'b0, "R11 idle");
            check(done && size_bytes == (ok ? ref_size(m2[2:0]) : 0), "R11 hold", size_bytes, ref_size(m2[2:0]));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        @(negedge clk);
        cyc(1'b0, 1'b0, 1'b0, "R1 reset");
        check(!done && !error && !err_timeout && !fast_req && size_bytes == 0, "R1 reset flags",
              {done, error, err_timeout, fast_req}, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cyc(1'b0, 1'b0, 1'b0, "R1 after reset");
        // Main case: device applies the write, 8 MiB
        run_seq(8'hC3, 8'hED, 8'h8B, 8'h55, 8'hA0, 8'h06, 1'b0, 1, -1, 0, -1, 1'b0);
        // Device ignoring the write, longest latency code, 32 MiB
        run_seq(8'h1C, 8'h0D, 8'h07, 8'h00, 8'h40, 8'h03, 1'b1, 3, -1, 0, -1, 1'b0);
        // R7 sweep of every density code
        for (int c = 0; c < 8; c++)
            run_seq(8'h00, 8'h0D, {5'b00010, 3'(c)}, 8'h00, 8'h20, 8'h01, 1'b0, 1, -1, 0, -1, 1'b0);
        // Wrong vendor code
        run_seq(8'h00, 8'h0C, 8'h03, 8'h00, 8'h00, 8'h00, 1'b0, 2, -1, 0, -1, 1'b0);
        // R9 done in last allowed wait cycle is accepted
        run_seq(8'h40, 8'h0D, 8'h81, 8'h00, 8'hE0, 8'h04, 1'b0, 1, 3, TO, -1, 1'b0);
        // R10 start pokes while busy and together with done
        run_seq(8'h00, 8'h0D, 8'h05, 8'h00, 8'h60, 8'h02, 1'b0, 3, -1, 0, -1, 1'b1);
        // R9 lost access on the address-2 read
        run_seq(8'h00, 8'h0D, 8'h03, 8'h00, 8'h00, 8'h00, 1'b0, 1, -1, 0, 3, 1'b0);
        // Recovery after a timeout
        run_seq(8'h00, 8'h0D, 8'h01, 8'h00, 8'h00, 8'h00, 1'b0, 1, -1, 0, -1, 1'b0);
        summary();
    end
endmodule